// File: doc/BRIEF.md
# Infrared Pulse Transmitter with Carrier Gating

The block plays out a stream of timed mark and space intervals on a single infrared drive pin. Software, or an upstream engine, writes records into a small internal queue. Each record carries a level bit (1 = mark, 0 = space) and a 16-bit duration counted in transmit ticks. A programmable divider derives the transmit tick from the system clock: one tick every `clk_div + 1` cycles. The sequencer pops one record, holds that level for the programmed number of ticks and then moves straight on to the next record. When the queue runs dry, the sequencer drops back to idle.

When modulation is on, every interval that carries a burst is chopped by a carrier. The carrier period is 16 ticks, and the carrier is high for the first `duty + 1` ticks of each period. By default marks carry the burst and spaces stay dark. A polarity control swaps these roles. A final inversion control flips the physical pin. A service-request flag tells the writer when to refill the queue, and an interrupt line gates that flag with an enable.

Top module: `ir_pulse_tx`

## Requirements
- R1: A record with duration count N ≥ 1 keeps its level for exactly N × (clk_div+1) clock cycles, measured from the clock edge that loads it. A count of 0 behaves like a count of 1.
- R2: When a record ends and the queue holds another record, the next record loads on that same edge, with no idle gap. The queue is never popped while it is empty.
- R3: With modulation on, the carrier restarts at the start of each record. Within each 16-tick carrier period, the carrier is high for ticks 0..duty and low for the remaining ticks.
- R4: With burst_on_space = 0, only marks are chopped by the carrier and spaces drive 0. With burst_on_space = 1, only spaces are chopped and marks drive 0.
- R5: With modulation off, the pre-inversion drive equals the level of the current record (1 for mark, 0 for space).
- R6: pin_invert = 1 inverts the final pin value in every state, including idle.
- R7: When no record is active, busy is 0 and the pin shows the idle value of 0 XOR pin_invert. busy is 1 while a record is being played.
- R8: With svc_on_any = 1, svc_req is 1 whenever the queue holds at least one entry. With svc_on_any = 0, svc_req is 1 whenever the queue holds at most DEPTH/2 entries (4 by default).
- R9: irq equals svc_req AND svc_irq_en.
- R10: With tx_en = 0, no record is loaded and busy clears on the next edge, so the pin returns to idle. Queued records are kept and play once tx_en returns to 1.
- R11: wr_full is 1 when the queue holds DEPTH entries. A write offered while the queue is full is dropped.
- R12: After a synchronous reset, the queue is empty, busy is 0, the pin is at its idle value and wr_full is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| mod_en | input | 1 | Carrier modulation enable |
| clk_div | input | 16 | Tick divider; one tick every clk_div+1 cycles |
| duty | input | 4 | Carrier high time is duty+1 ticks out of 16 |
| burst_on_space | input | 1 | 1: spaces carry the burst instead of marks |
| pin_invert | input | 1 | Inverts the final pin drive |
| svc_on_any | input | 1 | Service-request mode select |
| svc_irq_en | input | 1 | Interrupt enable for the service request |
| wr_valid | input | 1 | Write a record into the queue |
| wr_mark | input | 1 | Record level (1 = mark, 0 = space) |
| wr_dur | input | 16 | Record duration in ticks |
| wr_full | output | 1 | Queue full |
| ir_out | output | 1 | Infrared drive pin |
| busy | output | 1 | A record is being played |
| svc_req | output | 1 | Queue service requested |
| irq | output | 1 | Gated service interrupt |

## Verification
The bench aims at the edges of each record: durations of 0 and 1, back-to-back records, and the edge where the last record ends while a new write arrives. A design off by one tick would stretch or shorten every interval, and one that idles between records would insert a visible gap. The carrier checks cover duty values of 0 and 15, with and without swapped polarity. A carrier phase that is not restarted per record, or a wrong compare, would shift or lose the burst edges. Further runs disable the transmitter mid-record and overfill the queue while it is halted. These expose a busy flag that hangs high, a record that is lost, or a write that wraps a full queue.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    localparam int DUR_W = 16;
    localparam int PH_W  = 4;

    typedef struct packed {
        logic             mark;
        logic [DUR_W-1:0] dur;
    } ir_rec_t;

    typedef enum logic {
        SVC_HALF_OR_LESS = 1'b0,
        SVC_ANY_DATA     = 1'b1
    } svc_mode_e;

    function automatic logic carrier_high(input logic [PH_W-1:0] phase,
                                          input logic [PH_W-1:0] duty);
        return phase <= duty;
    endfunction

    function automatic logic pin_drive(input logic busy, input logic mark,
                                       input logic mod_on, input logic swap,
                                       input logic hi, input logic inv);
        logic raw;
        if (!busy)       raw = 1'b0;
        else if (mod_on) raw = (mark ^ swap) & hi;
        else             raw = mark;
        return raw ^ inv;
    endfunction

endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  ir_rec_t          din,
    input  logic             pop,
    output ir_rec_t          dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    ir_rec_t          mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push;

    assign empty   = (level == '0);
    assign full    = (level == FULL_LVL);
    assign do_push = push && !full;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + PTR_W'(1);
            if (pop)     rptr <= rptr + PTR_W'(1);
            case ({do_push, pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);                                  // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);                                                   // R2

endmodule

// File: rtl/ir_tx_ticker.sv
module ir_tx_ticker #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) cnt <= '0;
        else                                cnt <= cnt + DIV_W'(1);
    end

endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
    import ir_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            restart,
    input  logic [PH_W-1:0] duty,
    output logic            hi
);
    logic [PH_W-1:0] phase;

    assign hi = carrier_high(phase, duty);

    always_ff @(posedge clk) begin
        if (rst || restart) phase <= '0;
        else if (tick)      phase <= phase + PH_W'(1);
    end

    AST_CARRIER_WRAP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && phase == '1) |=> hi);                         // R3

endmodule

// File: rtl/ir_pulse_tx.sv
module ir_pulse_tx
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             mod_en,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [PH_W-1:0]  duty,
    input  logic             burst_on_space,
    input  logic             pin_invert,
    input  logic             svc_on_any,
    input  logic             svc_irq_en,
    input  logic             wr_valid,
    input  logic             wr_mark,
    input  logic [DUR_W-1:0] wr_dur,
    output logic             wr_full,
    output logic             ir_out,
    output logic             busy,
    output logic             svc_req,
    output logic             irq
);
    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

    ir_rec_t          wr_rec, head;
    logic             empty, tick, last_tick, load, carrier_hi;
    logic [LVL_W-1:0] level;
    logic [DUR_W-1:0] rem;
    logic             busy_q, mark_q;
    svc_mode_e        svc_mode;

    assign wr_rec    = '{mark: wr_mark, dur: wr_dur};
    assign last_tick = tick && (rem <= DUR_W'(1));
    assign load      = tx_en && !empty && (!busy_q || last_tick);

    ir_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(wr_valid), .din(wr_rec), .pop(load),
        .dout(head), .empty(empty), .full(wr_full), .level(level)
    );

    ir_tx_ticker #(.DIV_W(DIV_W)) u_ticker (
        .clk(clk), .rst(rst), .run(busy_q), .restart(load),
        .div(clk_div), .tick(tick)
    );

    ir_tx_carrier u_carrier (
        .clk(clk), .rst(rst), .tick(tick), .restart(load),
        .duty(duty), .hi(carrier_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            mark_q <= 1'b0;
            rem    <= '0;
        end else if (!tx_en) begin
            busy_q <= 1'b0;
            mark_q <= 1'b0;
        end else if (load) begin
            busy_q <= 1'b1;
            mark_q <= head.mark;
            rem    <= head.dur;
        end else if (last_tick) begin
            busy_q <= 1'b0;
            mark_q <= 1'b0;
        end else if (tick) begin
            rem    <= rem - DUR_W'(1);
        end
    end

    assign svc_mode = svc_mode_e'(svc_on_any);
    assign svc_req  = (svc_mode == SVC_ANY_DATA) ? (level != '0)
                                                 : (level <= HALF_LVL);
    assign irq      = svc_req && svc_irq_en;
    assign busy     = busy_q;
    assign ir_out   = pin_drive(busy_q, mark_q, mod_en, burst_on_space,
                                carrier_hi, pin_invert);

    AST_OFF_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !busy);                                                 // R10
    AST_IDLE_PIN: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ir_out == pin_invert));                                 // R7
    AST_REM_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && tx_en) |=> $stable(rem));                        // R1

endmodule

// File: tb/test_ir_pulse_tx.sv
module test_ir_pulse_tx;
    localparam int DEPTH = 8;

    logic        clk = 1'b0, rst = 1'b1;
    logic        tx_en = 0, mod_en = 0, burst_on_space = 0, pin_invert = 0;
    logic        svc_on_any = 0, svc_irq_en = 0, wr_valid = 0, wr_mark = 0;
    logic [15:0] clk_div = 0, wr_dur = 0;
    logic [3:0]  duty = 0;
    logic        wr_full, ir_out, busy, svc_req, irq;

    always #2.5 clk = ~clk;

    ir_pulse_tx #(.DEPTH(DEPTH)) i_ir_pulse_tx (
        .clk(clk), .rst(rst), .tx_en(tx_en), .mod_en(mod_en), .clk_div(clk_div),
        .duty(duty), .burst_on_space(burst_on_space), .pin_invert(pin_invert),
        .svc_on_any(svc_on_any), .svc_irq_en(svc_irq_en), .wr_valid(wr_valid),
        .wr_mark(wr_mark), .wr_dur(wr_dur), .wr_full(wr_full), .ir_out(ir_out),
        .busy(busy), .svc_req(svc_req), .irq(irq)
    );

    // behavioural reference
    logic [16:0] q[$];
    int  m_cnt, m_phase, m_rem;
    bit  m_busy, m_mark, started;
    int  vectors = 0, errors = 0, cycles = 0;
    bit  finished = 0;
    string cur_req = "R12";

    always @(posedge clk) begin
        bit tk, lst, ld, psh;
        logic [16:0] hd;
        cycles++;
        if (rst) begin
            q.delete(); m_cnt = 0; m_phase = 0; m_rem = 0;
            m_busy = 0; m_mark = 0; started = 1;
        end else begin
            tk  = m_busy && (m_cnt == int'(clk_div));
            lst = tk && (m_rem <= 1);
            ld  = tx_en && (q.size() > 0) && (!m_busy || lst);
            psh = wr_valid && (q.size() < DEPTH);
            hd  = '0;
            if (ld)  hd = q.pop_front();
            if (psh) q.push_back({wr_mark, wr_dur});
            if (!m_busy || ld || tk) m_cnt = 0; else m_cnt++;
            if (ld) m_phase = 0; else if (tk) m_phase = (m_phase + 1) % 16;
            if (!tx_en) begin m_busy = 0; m_mark = 0; end
            else if (ld) begin m_busy = 1; m_mark = hd[16]; m_rem = int'(hd[15:0]); end
            else if (lst) begin m_busy = 0; m_mark = 0; end
            else if (tk) m_rem--;
        end
    end

    task automatic cmp(string name, logic act, logic exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b",
                     cur_req, name, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit raw, e_svc;
        #1;
        if (started && !finished) begin
            vectors++;
            if (!m_busy)     raw = 0;
            else if (mod_en) raw = (m_mark ^ burst_on_space) && (m_phase <= int'(duty));
            else             raw = m_mark;
            e_svc = svc_on_any ? (q.size() != 0) : (q.size() <= DEPTH / 2);
            cmp("ir_out",  ir_out,  raw ^ pin_invert);
            cmp("busy",    busy,    m_busy);
            cmp("svc_req", svc_req, e_svc);
            cmp("irq",     irq,     e_svc && svc_irq_en);
            cmp("wr_full", wr_full, q.size() == DEPTH);
        end
    end

    task automatic push(bit mk, int d);
        @(negedge clk);
        wr_valid = 1; wr_mark = mk; wr_dur = 16'(d);
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!m_busy && q.size() == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    always @(posedge clk) if (cycles > 150000 && !finished) begin
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R12: reset state
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);

        // R5, R1, R2: unmodulated, divider 2, back-to-back incl. counts 0 and 1
        cur_req = "R5"; clk_div = 2; tx_en = 1;
        push(1, 4); push(0, 2); push(1, 1); push(0, 0); push(1, 3);
        cur_req = "R1"; drain();
        cur_req = "R2"; clk_div = 0;
        tx_en = 0; push(1, 2); push(0, 1); push(1, 1); tx_en = 1;
        drain();

        // R3: carrier, duty variants
        cur_req = "R3"; mod_en = 1; clk_div = 1;
        for (int d = 0; d < 16; d += 5) begin
            duty = 4'(d); push(1, 40); push(0, 5); drain();
        end
        duty = 15; push(1, 20); drain();

        // R4: swapped polarity
        cur_req = "R4"; burst_on_space = 1; duty = 7;
        push(0, 35); push(1, 6); push(0, 18); drain();
        burst_on_space = 0;

        // R6: pin inversion, modulated and plain
        cur_req = "R6"; pin_invert = 1;
        push(1, 20); push(0, 4); drain();
        mod_en = 0; push(1, 5); push(0, 3); drain();

        // R8, R9, R11: fill while halted, drop overflow
        cur_req = "R11"; tx_en = 0;
        for (int i = 0; i < DEPTH + 2; i++) push(i[0], i + 1);
        cur_req = "R8"; svc_on_any = 1; repeat (2) @(negedge clk);
        cur_req = "R9"; svc_irq_en = 1; repeat (2) @(negedge clk);
        svc_on_any = 0; repeat (2) @(negedge clk);
        cur_req = "R7"; tx_en = 1; drain();

        // R10: disable mid-record, keep queue, resume
        cur_req = "R10"; pin_invert = 0; mod_en = 1; duty = 3; clk_div = 3;
        push(1, 30); push(0, 4); push(1, 6);
        repeat (25) @(negedge clk);
        tx_en = 0; repeat (10) @(negedge clk);
        tx_en = 1; push(0, 2); drain();

        // R12: reset mid-stream
        cur_req = "R12"; push(1, 50); repeat (10) @(negedge clk);
        rst = 1; @(negedge clk); rst = 0; repeat (4) @(negedge clk);

        finish_run();
    end
endmodule